// File: doc/BRIEF.md
# Vertical Field Countdown Counter

This block turns a clock running at thirty-two times the line rate into the field timing of an interlaced raster. A prescaler produces a twice-line-rate enable, and a further toggle stage produces a square line-rate horizontal drive. A half-line counter is loaded with a preset at the start of every field and advances once per half-line. The field end depends on the mode. In standard mode the field ends on a fixed terminal count, and the vertical sync input is only compared against it. In the other mode an accepted sync pulse ends the field, sync that arrives too early is ignored, and a free-run ceiling ends the field when no sync arrives at all.

The counter is decoded into the pulses that the rest of the vertical chain needs: a ramp-charge pulse and a blanking pulse from the field start, a one-half-line coincidence window around the standard terminal count, and a noise-watch window over active scan. These go to an external mode controller, which also receives a one-clock coincidence flag and a one-clock field-end strobe, and which drives the standard-mode input. The field lengths are set by parameters. The defaults give 525 half-lines (8400 clocks) in standard mode, a hold-off of 492 half-lines (7872 clocks) and a ceiling of 684 half-lines (10944 clocks).

Top module: `vert_field_counter`

## Requirements
- R1: While `rst` is high every output is low. After `rst` falls, the counter runs from the preset with the prescaler cleared, so the first `field_end_o` appears STD_HL*DIV clocks after the first clock edge that sees `rst` low.
- R2: `hl_en_o` is high for one clock in every DIV clocks. `hdrive_o` toggles on exactly the clock edges where `hl_en_o` is high, so it has a period of 2*DIV clocks and is high for DIV of them.
- R3: With `std_mode_i` high a field lasts STD_HL half-lines (STD_HL*DIV clocks; 8400 by default) wherever `vsync_i` pulses fall.
- R4: `coinc_o` pulses for one clock, together with `field_end_o`, when `vsync_i` was high at any clock of the last standard half-line (half-line index STD_HL-1, counter value PRESET+STD_HL-1, one below the coincidence count 545). This holds in either mode. At no other time does `coinc_o` pulse.
- R5: With `std_mode_i` low, a `vsync_i` pulse in half-line index j ends the field after that half-line (length j+1) when j >= HOLD_HL. A pulse with j < HOLD_HL is ignored.
- R6: With `std_mode_i` low and no accepted sync, a field lasts MAX_HL half-lines (10944 clocks by default).
- R7: `field_end_o` is high for exactly one clock at each counter reload, in the first clock of the new field.
- R8: `ramp_o` is high for the first RAMP_HL half-lines of each field (192 clocks by default), starting in the clock where `field_end_o` is high.
- R9: `blank_o` is high for the first BLANK_HL half-lines of each field (608 clocks by default), starting in the clock where `field_end_o` is high.
- R10: `noise_win_o` is high for NOISE_HL half-lines beginning at half-line index BLANK_HL, and never overlaps `blank_o`.
- R11: `coinc_win_o` is high for the DIV clocks of half-line index STD_HL-1, and only in fields that reach that half-line.
- R12: The mode is sampled at every half-line boundary. If `std_mode_i` rises when the field is already past index STD_HL-1, the field ends at the next half-line boundary.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock at 32 times the line rate |
| rst | input | 1 | Synchronous active-high reset |
| vsync_i | input | 1 | Integrated vertical sync pulse |
| std_mode_i | input | 1 | Standard-mode select from the mode controller |
| hl_en_o | output | 1 | One-clock enable at twice the line rate |
| hdrive_o | output | 1 | Line-rate horizontal drive, 50% duty |
| field_end_o | output | 1 | One-clock strobe at each counter reload |
| coinc_o | output | 1 | One-clock flag: sync met the coincidence point |
| ramp_o | output | 1 | Ramp-charge pulse at field start |
| blank_o | output | 1 | Vertical blanking pulse at field start |
| coinc_win_o | output | 1 | Coincidence window, last standard half-line |
| noise_win_o | output | 1 | Noise-watch window over active scan |

## Verification
The hard case is the hold-off edge in the non-standard mode. A single sync pulse has to land in one chosen half-line, counted from a field boundary, and that half-line can only be found by following the block's own strobe. The bench locks onto `field_end_o`, counts clocks from it, and places one sync pulse in every possible half-line in turn, including the half-lines just below and at the hold-off and at the ceiling. A mode change late in a field is reached the same way: the bench lets a non-standard field run past the standard terminal count and raises the mode input there.

// File: rtl/vfc_pkg.sv
package vfc_pkg;

    // Decoded window set for one clock of the field.
    typedef struct packed {
        logic ramp;
        logic blank;
        logic cwin;
        logic nwin;
    } vf_win_t;

    // Reason the current half-line closes the field.
    typedef enum logic [1:0] {
        END_NONE  = 2'd0,
        END_FIXED = 2'd1,
        END_SYNC  = 2'd2,
        END_CEIL  = 2'd3
    } vf_end_t;

    function automatic int unsigned vfc_width(input int unsigned maxval);
        return (maxval < 2) ? 1 : $clog2(maxval + 1);
    endfunction

endpackage

// File: rtl/vfc_prescale.sv
module vfc_prescale #(
    parameter int unsigned DIV = 16
) (
    input  logic clk,
    input  logic rst,
    output logic hl_en,
    output logic hdrive
);
    localparam int unsigned PW = vfc_pkg::vfc_width(DIV - 1);
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] pre_q;

    assign hl_en = (pre_q == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q  <= '0;
            hdrive <= 1'b0;
        end else if (hl_en) begin
            pre_q  <= '0;
            hdrive <= ~hdrive;
        end else begin
            pre_q  <= pre_q + 1'b1;
        end
    end
endmodule

// File: rtl/vfc_field_ctr.sv
module vfc_field_ctr
    import vfc_pkg::*;
#(
    parameter int unsigned PRESET  = 20,
    parameter int unsigned STD_HL  = 525,
    parameter int unsigned HOLD_HL = 492,
    parameter int unsigned MAX_HL  = 684,
    parameter int unsigned CW      = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          hl_en,
    input  logic          std_i,
    input  logic          vsync_i,
    output logic [CW-1:0] idx_q,
    output logic [CW-1:0] idx_nxt,
    output vf_end_t       end_kind,
    output logic          coinc
);
    localparam logic [CW-1:0] C_PRE  = CW'(PRESET);
    localparam logic [CW-1:0] C_STDL = CW'(STD_HL - 1);
    localparam logic [CW-1:0] C_HOLD = CW'(HOLD_HL);
    localparam logic [CW-1:0] C_MAXL = CW'(MAX_HL - 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_nxt;
    logic          seen_q;
    logic          sync_hit;

    assign idx_q    = cnt_q - C_PRE;
    assign sync_hit = seen_q | vsync_i;
    assign coinc    = hl_en & sync_hit & (idx_q == C_STDL);

    always_comb begin
        end_kind = END_NONE;
        if (hl_en) begin
            if (std_i) begin
                if (idx_q >= C_STDL) end_kind = END_FIXED;
            end else if (sync_hit && idx_q >= C_HOLD) begin
                end_kind = END_SYNC;
            end else if (idx_q >= C_MAXL) begin
                end_kind = END_CEIL;
            end
        end
    end

    always_comb begin
        if (end_kind != END_NONE) cnt_nxt = C_PRE;
        else if (hl_en)           cnt_nxt = cnt_q + 1'b1;
        else                      cnt_nxt = cnt_q;
    end

    assign idx_nxt = cnt_nxt - C_PRE;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= C_PRE;
            seen_q <= 1'b0;
        end else begin
            cnt_q <= cnt_nxt;
            if (hl_en)        seen_q <= 1'b0;
            else if (vsync_i) seen_q <= 1'b1;
        end
    end
endmodule

// File: rtl/vfc_decode.sv
module vfc_decode
    import vfc_pkg::*;
#(
    parameter int unsigned STD_HL   = 525,
    parameter int unsigned RAMP_HL  = 12,
    parameter int unsigned BLANK_HL = 38,
    parameter int unsigned NOISE_HL = 384,
    parameter int unsigned CW       = 10
) (
    input  logic [CW-1:0] idx,
    output vf_win_t       win
);
    localparam logic [CW-1:0] C_RAMP = CW'(RAMP_HL);
    localparam logic [CW-1:0] C_BLNK = CW'(BLANK_HL);
    localparam logic [CW-1:0] C_NEND = CW'(BLANK_HL + NOISE_HL);
    localparam logic [CW-1:0] C_STDL = CW'(STD_HL - 1);

    always_comb begin
        win.ramp  = (idx < C_RAMP);
        win.blank = (idx < C_BLNK);
        win.nwin  = (idx >= C_BLNK) && (idx < C_NEND);
        win.cwin  = (idx == C_STDL);
    end
endmodule

// File: rtl/vert_field_counter.sv
module vert_field_counter
    import vfc_pkg::*;
#(
    parameter int unsigned DIV      = 16,
    parameter int unsigned PRESET   = 20,
    parameter int unsigned STD_HL   = 525,
    parameter int unsigned HOLD_HL  = 492,
    parameter int unsigned MAX_HL   = 684,
    parameter int unsigned RAMP_HL  = 12,
    parameter int unsigned BLANK_HL = 38,
    parameter int unsigned NOISE_HL = 384
) (
    input  logic clk,
    input  logic rst,
    input  logic vsync_i,
    input  logic std_mode_i,
    output logic hl_en_o,
    output logic hdrive_o,
    output logic field_end_o,
    output logic coinc_o,
    output logic ramp_o,
    output logic blank_o,
    output logic coinc_win_o,
    output logic noise_win_o
);
    localparam int unsigned CW = vfc_width(PRESET + MAX_HL);

    logic          hl_en;
    logic [CW-1:0] idx_q;
    logic [CW-1:0] idx_nxt;
    vf_end_t       end_kind;
    logic          coinc;
    vf_win_t       win_nxt;
    vf_win_t       win_q;
    logic          fe_q;
    logic          co_q;

    vfc_prescale #(.DIV(DIV)) u_pre (
        .clk    (clk),
        .rst    (rst),
        .hl_en  (hl_en),
        .hdrive (hdrive_o)
    );

    vfc_field_ctr #(
        .PRESET (PRESET),
        .STD_HL (STD_HL),
        .HOLD_HL(HOLD_HL),
        .MAX_HL (MAX_HL),
        .CW     (CW)
    ) u_ctr (
        .clk     (clk),
        .rst     (rst),
        .hl_en   (hl_en),
        .std_i   (std_mode_i),
        .vsync_i (vsync_i),
        .idx_q   (idx_q),
        .idx_nxt (idx_nxt),
        .end_kind(end_kind),
        .coinc   (coinc)
    );

    vfc_decode #(
        .STD_HL  (STD_HL),
        .RAMP_HL (RAMP_HL),
        .BLANK_HL(BLANK_HL),
        .NOISE_HL(NOISE_HL),
        .CW      (CW)
    ) u_dec (
        .idx(idx_nxt),
        .win(win_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            win_q <= '0;
            fe_q  <= 1'b0;
            co_q  <= 1'b0;
        end else begin
            win_q <= win_nxt;
            fe_q  <= (end_kind != END_NONE);
            co_q  <= coinc;
        end
    end

    assign hl_en_o     = hl_en;
    assign field_end_o = fe_q;
    assign coinc_o     = co_q;
    assign ramp_o      = win_q.ramp;
    assign blank_o     = win_q.blank;
    assign coinc_win_o = win_q.cwin;
    assign noise_win_o = win_q.nwin;
endmodule

// File: rtl/vfc_checker.sv
module vfc_checker #(
    parameter int unsigned CW      = 10,
    parameter int unsigned HOLD_HL = 492,
    parameter int unsigned MAX_HL  = 684
) (
    input logic          clk,
    input logic          rst,
    input logic          hl_en_o,
    input logic          hdrive_o,
    input logic          field_end_o,
    input logic          coinc_o,
    input logic          ramp_o,
    input logic          blank_o,
    input logic          noise_win_o,
    input logic [CW-1:0] idx_q
);
    assert_hdrive_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !hl_en_o |=> $stable(hdrive_o));

    assert_hdrive_toggle_R2: assert property (@(posedge clk) disable iff (rst)
        hl_en_o |=> (hdrive_o != $past(hdrive_o)));

    assert_coinc_at_end_R4: assert property (@(posedge clk) disable iff (rst)
        coinc_o |-> field_end_o);

    assert_holdoff_R5: assert property (@(posedge clk) disable iff (rst)
        field_end_o |-> ($past(idx_q) >= CW'(HOLD_HL)));

    assert_ceiling_R6: assert property (@(posedge clk) disable iff (rst)
        idx_q < CW'(MAX_HL));

    assert_start_pulses_R7: assert property (@(posedge clk) disable iff (rst)
        field_end_o |-> (ramp_o && blank_o));

    assert_no_overlap_R10: assert property (@(posedge clk) disable iff (rst)
        !(noise_win_o && blank_o));
endmodule

bind vert_field_counter vfc_checker #(
    .CW     (CW),
    .HOLD_HL(HOLD_HL),
    .MAX_HL (MAX_HL)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .hl_en_o    (hl_en_o),
    .hdrive_o   (hdrive_o),
    .field_end_o(field_end_o),
    .coinc_o    (coinc_o),
    .ramp_o     (ramp_o),
    .blank_o    (blank_o),
    .noise_win_o(noise_win_o),
    .idx_q      (idx_q)
);

// File: tb/vert_field_counter_test.sv
`timescale 1ns/1ps
module vert_field_counter_test;
    localparam int DIV = 4, PRESET = 3, STD = 21, HOLD = 12, MAXL = 27;
    localparam int RAMP = 2, BLANK = 4, NOISE = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic vs_r = 1'b0;
    logic std_r = 1'b1;
    logic hl_en_o, hdrive_o, field_end_o, coinc_o, ramp_o, blank_o, coinc_win_o, noise_win_o;

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    vert_field_counter #(
        .DIV(DIV), .PRESET(PRESET), .STD_HL(STD), .HOLD_HL(HOLD), .MAX_HL(MAXL),
        .RAMP_HL(RAMP), .BLANK_HL(BLANK), .NOISE_HL(NOISE)
    ) uut (
        .clk(clk), .rst(rst), .vsync_i(vs_r), .std_mode_i(std_r),
        .hl_en_o(hl_en_o), .hdrive_o(hdrive_o), .field_end_o(field_end_o),
        .coinc_o(coinc_o), .ramp_o(ramp_o), .blank_o(blank_o),
        .coinc_win_o(coinc_win_o), .noise_win_o(noise_win_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Entered at the negedge where field_end_o is high (t=0).
    task automatic run_field(input int sync_hl, input int switch_hl, output int len,
                             output int co, output int n_ramp, output int n_blank,
                             output int n_cwin, output int n_nwin, output int n_hderr,
                             output int n_hlen);
        int t = 0;
        logic hd_prev;
        hd_prev = hdrive_o;
        n_ramp = int'(ramp_o); n_blank = int'(blank_o);
        n_cwin = int'(coinc_win_o); n_nwin = int'(noise_win_o);
        n_hderr = 0; n_hlen = int'(hl_en_o); len = -1; co = 0;
        forever begin
            vs_r = (sync_hl >= 0) && (t == sync_hl * DIV + 1);
            if (switch_hl >= 0 && t == switch_hl * DIV + 1) std_r = ~std_r;
            @(negedge clk);
            t++;
            if ((t % DIV == 0) != (hdrive_o != hd_prev)) n_hderr++;
            hd_prev = hdrive_o;
            if (field_end_o) begin
                len = t; co = int'(coinc_o); vs_r = 1'b0;
                break;
            end
            n_ramp += int'(ramp_o); n_blank += int'(blank_o);
            n_cwin += int'(coinc_win_o); n_nwin += int'(noise_win_o);
            n_hlen += int'(hl_en_o);
            if (t > 4 * MAXL * DIV) begin
                vs_r = 1'b0;
                break;
            end
        end
    endtask

    task automatic check_field(input string tag, input int sync_hl, input int switch_hl,
                               input int exp_hl, input int exp_co);
        int len, co, nr, nb, nc, nn, nh, nhl;
        run_field(sync_hl, switch_hl, len, co, nr, nb, nc, nn, nh, nhl);
        chk({tag, " length R3 R5 R6 R12"}, len, exp_hl * DIV);
        chk({tag, " coinc R4"}, co, exp_co);
        chk({tag, " ramp R8"}, nr, RAMP * DIV);
        chk({tag, " blank R9"}, nb, BLANK * DIV);
        chk({tag, " noise R10"}, nn, NOISE * DIV);
        chk({tag, " cwin R11"}, nc, (exp_hl >= STD) ? DIV : 0);
        chk({tag, " hdrive R2"}, nh, 0);
        chk({tag, " hl_en R2"}, nhl, exp_hl);
    endtask

    initial begin
        while (cyc < 200000) begin
            @(posedge clk);
            cyc++;
        end
        n_chk++; n_err++;
        $display("FAIL watchdog R1 actual=%0d expected=%0d", cyc, 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        int t;
        repeat (6) @(negedge clk);
        // R1: all outputs low in reset
        chk("reset outputs R1",
            int'({hl_en_o, hdrive_o, field_end_o, coinc_o, ramp_o, blank_o, coinc_win_o, noise_win_o}), 0);
        rst = 1'b0;
        t = 0;
        while (!field_end_o && t < 4 * MAXL * DIV) begin
            @(negedge clk);
            t++;
        end
        chk("first field after reset R1", t, STD * DIV);
        chk("field_end with ramp R7 R8", int'(ramp_o && blank_o), 1);

        // Standard mode: sync anywhere never changes the length.
        std_r = 1'b1;
        for (int j = -1; j < STD; j++)
            check_field($sformatf("std sync=%0d", j), j, -1, STD, (j == STD - 1) ? 1 : 0);

        // Non-standard mode: sweep the single sync pulse over every half-line.
        std_r = 1'b0;
        for (int j = -1; j < MAXL; j++)
            check_field($sformatf("nstd sync=%0d", j), j, -1,
                        (j >= HOLD) ? j + 1 : MAXL, (j == STD - 1) ? 1 : 0);

        // R12: mode rises after the standard terminal count.
        std_r = 1'b0;
        check_field("switch late R12", -1, 23, 24, 0);
        chk("mode after switch R12", int'(std_r), 1);
        // Rises early: standard length applies.
        std_r = 1'b0;
        check_field("switch early R12", -1, 5, STD, 0);
        // Falls mid-field, then sync past the hold-off is accepted.
        std_r = 1'b1;
        check_field("switch to nstd R5", 16, 15, 17, 0);
        std_r = 1'b1;
        check_field("back to std R3", -1, -1, STD, 0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule